// File: doc/BRIEF.md
# UART Channel FIFO Control with DMA-Ready Signalling

This block is the queueing and flow-control stage of one UART channel. It sits between the host register interface and the serial shifters. It holds a transmit byte queue and a receive byte queue, each sixteen entries deep. A single control-byte write port configures it. Through that port software can turn queueing on or off, flush either queue, pick the receive trigger depth and choose how the two active-low DMA request outputs behave.

With queueing off, each direction acts as a one-byte holding register. With queueing on, each direction buffers up to sixteen bytes. The transmit-ready output and the receive-ready output then follow one of two styles. In the per-character style, each request reflects whether one byte can move. In the level style, the transmit request stays active until the queue is full. The receive request starts when the trigger depth or a receive timeout is reached, and it stays active until the queue drains. The block also drives the queueing-status bits and the pending bit of the interrupt identification byte.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both counts are 0, `cfg_q` is 0x00, `txrdy_n` is 0, `rxrdy_n` is 1, `rx_q`/`tx_q` are 0 and `iir_fifo_bits` is 00.
- R2: Bit 0 of a control write enables queueing. While it is 0, each queue holds at most one byte and further pushes are dropped.
- R3: A control write with bit 1 set empties the receive queue (count 0 on the next cycle) and leaves the transmit queue intact.
- R4: A control write with bit 2 set empties the transmit queue and leaves the receive queue intact.
- R5: A control write that changes bit 0 empties both queues.
- R6: `cfg_q` reads back as {trigger[7:6], 0, 0, mode[3], 0, 0, enable[0]}. The flush bits always read 0, and bits 5:4 are unused and read 0.
- R7: Bits 7:6 set the receive trigger depth: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes.
- R8: In mode 0 (bit 3 clear), or with queueing off, `txrdy_n` is 0 exactly when the transmit count is 0.
- R9: In mode 0, or with queueing off, `rxrdy_n` is 0 exactly when the receive count is non-zero.
- R10: In mode 1 (bit 3 set) with queueing on, `txrdy_n` is 1 exactly when the transmit count is 16.
- R11: In mode 1 with queueing on, `rxrdy_n` goes 0 when the count reaches the trigger depth, or one cycle after `rx_timeout` is seen with a non-empty queue. It then stays 0 until the count is 0.
- R12: `iir_fifo_bits` reads 11 while queueing is on and 00 otherwise. `iir_nopend` is 0 while `irq_pend` is 1.
- R13: Each queue holds 16 bytes in first-in first-out order. A receive push to a full queue is dropped, and `rx_overrun` pulses high for one cycle after it.
- R14: A flush in the same cycle as a push or pop wins: the push is discarded and the pop is ignored. A pop from an empty queue leaves the count and the output byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte written |
| cfg_q | output | 8 | Control byte readback |
| tx_push | input | 1 | Host loads a transmit byte |
| tx_data | input | 8 | Transmit byte from host |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_q | output | 8 | Byte most recently taken by the transmit shifter |
| tx_count | output | 5 | Transmit queue occupancy |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a receive byte |
| rx_q | output | 8 | Byte most recently read by the host |
| rx_count | output | 5 | Receive queue occupancy |
| rx_overrun | output | 1 | One-cycle pulse after a dropped receive push |
| rx_timeout | input | 1 | Receive character timeout indication |
| txrdy_n | output | 1 | Active-low transmit DMA request |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| irq_pend | input | 1 | Interrupt pending from the priority logic |
| iir_fifo_bits | output | 2 | Queueing status bits of the identification byte |
| iir_nopend | output | 1 | Identification bit 0, low when an interrupt is pending |

## Verification
Two functions can land in the same cycle: a control write that flushes a queue, and a push or pop on that queue. The bench provokes this on purpose in a directed step, where a receive flush is written while a byte arrives. It provokes it again throughout a long random phase, where rare control writes overlap random traffic. The cycle is judged against a queue-based model: after the edge the count must be zero, and no overrun pulse or output-byte change may appear. A second overlap is also covered, a receive timeout arriving together with the trigger depth being reached or the queue draining, and the level-mode request is compared on every cycle.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Control byte field positions that neighbouring logic decodes
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_RXCLR_BIT = 1;
  localparam int CFG_TXCLR_BIT = 2;
  localparam int CFG_MODE_BIT  = 3;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_FOUR     = 2'b01,
    TRIG_EIGHT    = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } rx_trig_e;

  function automatic int unsigned trig_depth(rx_trig_e sel);
    case (sel)
      TRIG_ONE:   return 1;
      TRIG_FOUR:  return 4;
      TRIG_EIGHT: return 8;
      default:    return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] q_q, q_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && !clr && (cnt_q < cap);
  assign do_pop  = pop && !clr && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    q_d   = q_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = ptr_inc(wp_q);
      if (do_pop) begin
        rp_d = ptr_inc(rp_q);
        q_d  = mem[rp_q];
      end
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      q_q   <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign count = cnt_q;
  assign q     = q_q;

endmodule

// File: rtl/uart_dma_rdy.sv
module uart_dma_rdy #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [CW-1:0] trig,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_timeout,
  output logic          txrdy_n,
  output logic          rxrdy_n
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic lvl_mode, rx_has, rx_hit;
  logic arm_q, arm_d;

  assign lvl_mode = fifo_en && dma_mode;
  assign rx_has   = (rx_count != '0);
  assign rx_hit   = (rx_count >= trig);

  // Latch a receive request once trigger or timeout is seen; drop on empty
  always_comb begin
    arm_d = rx_has && (arm_q || rx_hit || rx_timeout);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  always_comb begin
    if (lvl_mode) begin
      txrdy_n = (tx_count == FULL);
      rxrdy_n = !(rx_has && (arm_q || rx_hit));
    end else begin
      txrdy_n = (tx_count != '0);
      rxrdy_n = !rx_has;
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_q,
  input  logic          tx_push,
  input  logic [7:0]    tx_data,
  input  logic          tx_pop,
  output logic [7:0]    tx_q,
  output logic [CW-1:0] tx_count,
  input  logic          rx_push,
  input  logic [7:0]    rx_data,
  input  logic          rx_pop,
  output logic [7:0]    rx_q,
  output logic [CW-1:0] rx_count,
  output logic          rx_overrun,
  input  logic          rx_timeout,
  output logic          txrdy_n,
  output logic          rxrdy_n,
  input  logic          irq_pend,
  output logic [1:0]    iir_fifo_bits,
  output logic          iir_nopend
);

  logic          en_q, en_d, mode_q, mode_d;
  rx_trig_e      trig_q, trig_d;
  logic          en_chg, rx_clr, tx_clr;
  logic [CW-1:0] cap, trig_cnt;
  logic          ovr_q, ovr_d;

  assign en_chg = cfg_we && (cfg_wdata[CFG_EN_BIT] != en_q);
  assign rx_clr = cfg_we && (cfg_wdata[CFG_RXCLR_BIT] || en_chg);
  assign tx_clr = cfg_we && (cfg_wdata[CFG_TXCLR_BIT] || en_chg);
  assign cap    = en_q ? CW'(DEPTH) : CW'(1);

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    trig_d = trig_q;
    if (cfg_we) begin
      en_d   = cfg_wdata[CFG_EN_BIT];
      mode_d = cfg_wdata[CFG_MODE_BIT];
      trig_d = rx_trig_e'(cfg_wdata[7:6]);
    end
    ovr_d = rx_push && !rx_clr && (rx_count >= cap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      trig_q <= TRIG_ONE;
      ovr_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      trig_q <= trig_d;
      ovr_q  <= ovr_d;
    end
  end

  assign trig_cnt = CW'(trig_depth(trig_q));

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap(cap),
    .push(tx_push), .din(tx_data), .pop(tx_pop),
    .count(tx_count), .q(tx_q)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap(cap),
    .push(rx_push), .din(rx_data), .pop(rx_pop),
    .count(rx_count), .q(rx_q)
  );

  uart_dma_rdy #(.DEPTH(DEPTH)) u_rdy (
    .clk(clk), .rst_n(rst_n), .fifo_en(en_q), .dma_mode(mode_q),
    .trig(trig_cnt), .tx_count(tx_count), .rx_count(rx_count),
    .rx_timeout(rx_timeout), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  assign cfg_q         = {trig_q, 2'b00, mode_q, 2'b00, en_q};
  assign rx_overrun    = ovr_q;
  assign iir_fifo_bits = {en_q, en_q};
  assign iir_nopend    = !irq_pend;

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk
  import uart_fifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    cfg_q,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [7:0]    rx_q,
  input logic          rx_overrun,
  input logic          txrdy_n,
  input logic          rxrdy_n,
  input logic          irq_pend,
  input logic [1:0]    iir_fifo_bits,
  input logic          iir_nopend
);

  logic          lvl;
  logic [CW-1:0] cap_c, trig_c;
  assign lvl    = cfg_q[0] && cfg_q[3];
  assign cap_c  = cfg_q[0] ? CW'(DEPTH) : CW'(1);
  assign trig_c = CW'(trig_depth(rx_trig_e'(cfg_q[7:6])));

  p_disabled_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |-> (rx_count <= CW'(1)) && (tx_count <= CW'(1)));

  p_rx_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[1] |=> rx_count == '0);

  p_tx_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[2] |=> tx_count == '0);

  p_en_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_wdata[0] != cfg_q[0]) |=> (rx_count == '0) && (tx_count == '0));

  p_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == {$past(cfg_wdata[7:6]), 2'b00, $past(cfg_wdata[3]), 2'b00, $past(cfg_wdata[0])});

  p_trigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl && (rx_count >= trig_c) |-> !rxrdy_n);

  p_tx_char_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |-> txrdy_n == (tx_count != '0));

  p_rx_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |-> rxrdy_n == (rx_count == '0));

  p_tx_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl |-> txrdy_n == (tx_count == CW'(DEPTH)));

  p_rx_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> rxrdy_n);

  p_iir_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_fifo_bits == {cfg_q[0], cfg_q[0]}) && (iir_nopend == !irq_pend));

  p_overrun_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_pop && !cfg_we && (rx_count == cap_c) |=> rx_overrun && $stable(rx_count));

  p_depth_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  p_empty_pop_r14: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && !rx_push && (rx_count == '0) |=> $stable(rx_q) && (rx_count == '0));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_q(cfg_q), .tx_count(tx_count), .rx_count(rx_count),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_q(rx_q), .rx_overrun(rx_overrun),
  .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .irq_pend(irq_pend),
  .iir_fifo_bits(iir_fifo_bits), .iir_nopend(iir_nopend)
);

// File: tb/uart_fifo_ctrl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_bench;

  logic       clk, rst_n;
  logic       cfg_we;  logic [7:0] cfg_wdata; logic [7:0] cfg_q;
  logic       tx_push; logic [7:0] tx_data;   logic tx_pop; logic [7:0] tx_q; logic [4:0] tx_count;
  logic       rx_push; logic [7:0] rx_data;   logic rx_pop; logic [7:0] rx_q; logic [4:0] rx_count;
  logic       rx_overrun, rx_timeout, txrdy_n, rxrdy_n, irq_pend, iir_nopend;
  logic [1:0] iir_fifo_bits;

  uart_fifo_ctrl u_uart_fifo_ctrl (.*);

  int n_chk = 0, n_fail = 0;

  // Reference model state
  bit         m_en, m_mode, m_arm, m_ovr;
  logic [1:0] m_tsel;
  logic [7:0] m_txq[$], m_rxq[$];
  logic [7:0] m_txo, m_rxo;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int lvl_of(logic [1:0] s);
    case (s) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_mode = 0; m_arm = 0; m_ovr = 0; m_tsel = 2'b00;
    m_txq.delete(); m_rxq.delete(); m_txo = 8'h00; m_rxo = 8'h00;
  endtask

  task automatic model_update();
    int  cap = m_en ? 16 : 1;
    int  tpre = m_txq.size(), rpre = m_rxq.size();
    bit  chg = cfg_we && (cfg_wdata[0] != m_en);
    bit  cr = cfg_we && (cfg_wdata[1] || chg);
    bit  ct = cfg_we && (cfg_wdata[2] || chg);
    bit  arm_n = (rpre != 0) && (m_arm || rpre >= lvl_of(m_tsel) || rx_timeout);
    m_ovr = 0;
    if (ct) m_txq.delete();
    else begin
      if (tx_pop && tpre > 0) m_txo = m_txq.pop_front();
      if (tx_push && tpre < cap) m_txq.push_back(tx_data);
    end
    if (cr) m_rxq.delete();
    else begin
      if (rx_pop && rpre > 0) m_rxo = m_rxq.pop_front();
      if (rx_push && rpre < cap) m_rxq.push_back(rx_data);
      m_ovr = rx_push && (rpre >= cap);
    end
    if (cfg_we) begin
      m_en = cfg_wdata[0]; m_mode = cfg_wdata[3]; m_tsel = cfg_wdata[7:6];
    end
    m_arm = arm_n;
  endtask

  task automatic compare();
    bit lv = m_en && m_mode;
    int rs = m_rxq.size();
    check("R13 tx_count", tx_count, m_txq.size());
    check("R13 rx_count", rx_count, rs);
    check("R13 rx_overrun", rx_overrun, m_ovr);
    check("R14 tx_q", tx_q, m_txo);
    check("R14 rx_q", rx_q, m_rxo);
    check("R6 cfg_q", cfg_q, {m_tsel, 2'b00, m_mode, 2'b00, m_en});
    check("R12 iir_fifo_bits", iir_fifo_bits, {m_en, m_en});
    check("R12 iir_nopend", iir_nopend, !irq_pend);
    if (lv) begin
      check("R10 txrdy_n", txrdy_n, m_txq.size() == 16);
      check("R11 rxrdy_n", rxrdy_n, !(rs != 0 && (m_arm || rs >= lvl_of(m_tsel))));
    end else begin
      check("R8 txrdy_n", txrdy_n, m_txq.size() != 0);
      check("R9 rxrdy_n", rxrdy_n, rs == 0);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_wdata = 8'h00; tx_push = 0; tx_data = 8'h00; tx_pop = 0;
    rx_push = 0; rx_data = 8'h00; rx_pop = 0; rx_timeout = 0; irq_pend = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic wr_cfg(logic [7:0] v); cfg_we = 1; cfg_wdata = v; step(); endtask
  task automatic put_rx(logic [7:0] v); rx_push = 1; rx_data = v; step(); endtask
  task automatic put_tx(logic [7:0] v); tx_push = 1; tx_data = v; step(); endtask
  task automatic get_rx(); rx_pop = 1; step(); endtask
  task automatic get_tx(); tx_pop = 1; step(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 txrdy_n", txrdy_n, 0);
    check("R1 rxrdy_n", rxrdy_n, 1);
    check("R1 cfg_q", cfg_q, 0);
    check("R1 counts", tx_count + rx_count, 0);
    check("R1 iir_fifo_bits", iir_fifo_bits, 0);
    rst_n = 1;
    step();

    // R2: queueing off keeps one byte
    put_rx(8'hA1);
    put_rx(8'hA2);
    check("R2 rx_count single", rx_count, 1);
    check("R13 overrun pulse", rx_overrun, 1);
    get_rx();
    check("R2 rx_q", rx_q, 8'hA1);
    put_tx(8'h55);
    check("R8 txrdy_n loaded", txrdy_n, 1);

    // R5: enabling flushes both
    put_rx(8'h11);
    wr_cfg(8'h01);
    check("R5 tx flushed", tx_count, 0);
    check("R5 rx flushed", rx_count, 0);
    check("R12 iir on", iir_fifo_bits, 3);

    // R13: depth 16
    for (int i = 0; i < 17; i++) put_tx(8'(8'h20 + i));
    check("R13 tx full", tx_count, 16);
    wr_cfg(8'h09);
    check("R10 full high", txrdy_n, 1);
    get_tx();
    check("R10 space low", txrdy_n, 0);
    check("R13 fifo order", tx_q, 8'h20);

    // R4: transmit flush, receive untouched
    put_rx(8'h77);
    wr_cfg(8'h05);
    check("R4 tx flushed", tx_count, 0);
    check("R4 rx kept", rx_count, 1);
    check("R6 flush bit reads 0", cfg_q, 8'h01);

    // R3/R14: receive flush with simultaneous push
    put_rx(8'h78); put_rx(8'h79);
    put_tx(8'h44);
    cfg_we = 1; cfg_wdata = 8'h03; rx_push = 1; rx_data = 8'hEE; rx_pop = 1; step();
    check("R3 rx flushed", rx_count, 0);
    check("R3 tx kept", tx_count, 1);
    check("R14 pop ignored on flush", rx_q, 8'hA1);
    check("R14 no overrun on flush", rx_overrun, 0);
    get_rx();
    check("R14 empty pop", rx_q, 8'hA1);

    // R7/R11: level mode, trigger four
    wr_cfg(8'h49);
    for (int i = 0; i < 3; i++) put_rx(8'(8'h30 + i));
    check("R11 below trigger", rxrdy_n, 1);
    put_rx(8'h33);
    check("R7 trigger four", rxrdy_n, 0);
    for (int i = 0; i < 3; i++) get_rx();
    check("R11 held until empty", rxrdy_n, 0);
    get_rx();
    check("R11 released on empty", rxrdy_n, 1);
    put_rx(8'h40);
    rx_timeout = 1; step();
    check("R11 timeout", rxrdy_n, 0);
    get_rx();

    // R7: trigger fourteen
    wr_cfg(8'hC9);
    for (int i = 0; i < 13; i++) put_rx(8'(i));
    check("R7 thirteen high", rxrdy_n, 1);
    put_rx(8'h0D);
    check("R7 fourteen low", rxrdy_n, 0);

    // R12 and R5 on disable
    irq_pend = 1; step();
    wr_cfg(8'h00);
    check("R5 disable flush", rx_count, 0);
    check("R12 iir off", iir_fifo_bits, 0);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        cfg_we = 1;
        cfg_wdata = 8'($urandom);
        if ($urandom_range(0, 3) != 0) cfg_wdata[0] = m_en;
        if ($urandom_range(0, 1) != 0) cfg_wdata[2:1] = 2'b00;
      end
      tx_push = 1'($urandom); tx_data = 8'($urandom); tx_pop = ($urandom_range(0, 2) == 0);
      rx_push = 1'($urandom); rx_data = 8'($urandom); rx_pop = ($urandom_range(0, 2) == 0);
      rx_timeout = ($urandom_range(0, 19) == 0);
      irq_pend = 1'($urandom);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule